// File: doc/BRIEF.md
# Vectored IRQ/FIQ Interrupt Controller

This block collects up to 96 level-sensitive interrupt lines, grouped into three banks of 32, and turns them into two processor requests: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each line is sampled into a raw pending bit every clock. A per-bank mask suppresses lines. A per-bank route register sends unmasked lines to the fast request as well as the normal one. A vector word gives software the lowest-numbered unmasked pending line without a bit scan.

Software reaches the block through a plain 32-bit word-addressed register port inside a 1 KB byte window. A write happens in any cycle where `bus_we_i` is high. Read data is a combinational function of `bus_addr_i`. There is no back-pressure: every access completes in the cycle it is presented.

The register layout is as follows. Control words sit at 0x00 (vector), 0x04 (base), 0x08 (protect) and 0x0C (NMI control). Each per-bank group holds three words at offsets +0x0, +0x4 and +0x8, one word per bank, and the groups start at:

- raw pending: 0x10
- sticky fast pending: 0x20
- route: 0x30
- enable: 0x40
- mask: 0x50

Top module: `irqfiq_ctrl`

## Requirements
- R1: Bit n%32 of the raw pending word for bank n/32 (read at 0x10 + 4*bank) equals the level of `src_i[n]` sampled at the previous rising clock edge.
- R2: `irq_o` is high exactly when some line is raw pending and its mask bit (0x50 + 4*bank, 1 = masked) is 0.
- R3: `fiq_o` is high exactly when some line is raw pending, not masked, and has its route bit (0x30 + 4*bank, 1 = fast) set.
- R4: The vector word at 0x00 reads 4*(32*bank + bit) for the unmasked pending line with the lowest bank, and within that bank the lowest bit. It reads 0 when no unmasked line is pending, and writes to 0x00 have no effect.
- R5: Writes to the raw pending words (0x10, 0x14, 0x18) change nothing.
- R6: A sticky fast pending bit (0x20 + 4*bank) is set on each clock where its line is raw pending, unmasked and routed fast. A write clears the bits that are 1 in the written data. If a bit is being set and cleared in the same clock, it ends up set.
- R7: A write to the base word (0x04) stores the data with bits [1:0] forced to 0. The protect (0x08) and NMI control (0x0C) words store all 32 written bits.
- R8: The enable words (0x40 + 4*bank) read back what was written and have no effect on `irq_o`, `fiq_o` or the vector.
- R9: Reads from an unmapped offset return 0, and writes to one change nothing. Unmapped offsets are a bank slot of 3 (for example 0x1C), any offset at 0x60 or above, and any offset whose bits [1:0] are not 0.
- R10: While `rst_i` is high at a rising edge, every register is cleared to 0, so all words read 0 and both requests are low afterwards.
- R11: Within a per-bank group, address bits [3:2] choose the bank. A write to one bank's word leaves the other banks' words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | 96 | Level-sensitive interrupt lines |
| bus_addr_i | input | 10 | Byte address inside the register window |
| bus_we_i | input | 1 | Write strobe for the addressed word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Several checks run on every cycle:
- a fast request never appears without a normal request;
- the vector is 0 whenever the normal request is low, and it is always word-aligned and inside the line range;
- base bits [1:0] are always 0;
- raw pending always tracks the previous input sample;
- a clearing write never leaves a written bit set unless that line is still asserting a fast request.

Other behaviour can only be shown by the bench's scenarios:
- the priority order of the vector across banks and within a bank;
- mask and route combinations;
- the "set beats clear" case;
- unmapped and misaligned accesses;
- bank isolation within a group;
- reset in the middle of traffic.

// File: rtl/irqfiq_pkg.sv
package irqfiq_pkg;
  localparam int DATA_W    = 32;
  localparam int BANK_W    = 32;
  localparam int ADDR_W    = 10;
  localparam int GRP_W     = ADDR_W - 4;

  // Register group selected by address bits [ADDR_W-1:4]
  typedef enum logic [GRP_W-1:0] {
    GRP_CTRL = 6'd0,
    GRP_RAW  = 6'd1,
    GRP_FPND = 6'd2,
    GRP_ROUTE = 6'd3,
    GRP_ENA  = 6'd4,
    GRP_MASK = 6'd5
  } grp_e;

  // Word within the control group, address bits [3:2]
  typedef enum logic [1:0] {
    CW_VEC  = 2'd0,
    CW_BASE = 2'd1,
    CW_PROT = 2'd2,
    CW_NMI  = 2'd3
  } ctrl_word_e;
endpackage

// File: rtl/irqfiq_bank.sv
module irqfiq_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [BANK_W-1:0] src_i,
  input  logic              we_fpnd_i,
  input  logic              we_route_i,
  input  logic              we_ena_i,
  input  logic              we_mask_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] pend_o,
  output logic [BANK_W-1:0] fpnd_o,
  output logic [BANK_W-1:0] route_o,
  output logic [BANK_W-1:0] ena_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] act_o,
  output logic [BANK_W-1:0] fact_o
);
  logic [BANK_W-1:0] pend_q, fpnd_q, route_q, ena_q, mask_q;
  logic [BANK_W-1:0] fpnd_kept;

  assign act_o  = pend_q & ~mask_q;
  assign fact_o = act_o & route_q;

  // Clear requested bits first, then OR in live fast requests so that set wins
  assign fpnd_kept = we_fpnd_i ? (fpnd_q & ~wdata_i) : fpnd_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q  <= '0;
      fpnd_q  <= '0;
      route_q <= '0;
      ena_q   <= '0;
      mask_q  <= '0;
    end else begin
      pend_q <= src_i;
      fpnd_q <= fpnd_kept | fact_o;
      if (we_route_i) route_q <= wdata_i;
      if (we_ena_i)   ena_q   <= wdata_i;
      if (we_mask_i)  mask_q  <= wdata_i;
    end
  end

  assign pend_o  = pend_q;
  assign fpnd_o  = fpnd_q;
  assign route_o = route_q;
  assign ena_o   = ena_q;
  assign mask_o  = mask_q;

  // R1: raw pending is the previous sample of the lines
  p_pend_tracks_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (pend_q == $past(src_i)));

  // R6: a clearing write leaves no written bit set unless it was re-set
  p_fpnd_w1c_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(we_fpnd_i) |-> ((fpnd_q & $past(wdata_i) & ~$past(fact_o)) == '0));

  // R6: without a clearing write, sticky bits never drop
  p_fpnd_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(we_fpnd_i) |-> ((fpnd_q & $past(fpnd_q)) == $past(fpnd_q)));
endmodule

// File: rtl/irqfiq_scan.sv
module irqfiq_scan #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int DATA_W    = 32
) (
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] act_i,
  output logic [DATA_W-1:0]                vec_o
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;
  localparam int LOW_W   = $clog2(BANK_W);
  localparam int IDX_W   = $clog2(NUM_SRC);

  logic [NUM_BANKS-1:0]            hit;
  logic [NUM_BANKS-1:0][LOW_W-1:0] low;
  logic [IDX_W-1:0]                idx;

  // Stage 1: per bank, lowest set bit; stage 2: lowest bank with a hit
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      hit[b] = |act_i[b];
      low[b] = '0;
      for (int i = BANK_W - 1; i >= 0; i--) begin
        if (act_i[b][i]) low[b] = LOW_W'(i);
      end
    end
    idx = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (hit[b]) idx = IDX_W'(b * BANK_W) + IDX_W'(low[b]);
    end
    vec_o = DATA_W'(idx) << 2;
  end
endmodule

// File: rtl/irqfiq_ctrl.sv
module irqfiq_ctrl
  import irqfiq_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic [NUM_BANKS*BANK_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic                          bus_we_i,
  input  logic [DATA_W-1:0]             bus_wdata_i,
  output logic [DATA_W-1:0]             bus_rdata_o,
  output logic                          irq_o,
  output logic                          fiq_o
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;

  logic        aligned;
  grp_e        grp;
  logic [1:0]  slot;
  logic        slot_ok;

  logic [NUM_BANKS-1:0][BANK_W-1:0] pend, fpnd, route, ena, mask, act, fact;
  logic [NUM_BANKS-1:0]             any_act, any_fact;
  logic [DATA_W-1:0]                vec;
  logic [DATA_W-1:0]                base_q, prot_q, nmi_q;

  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign grp     = grp_e'(bus_addr_i[ADDR_W-1:4]);
  assign slot    = bus_addr_i[3:2];
  assign slot_ok = (32'(slot) < NUM_BANKS);

  // Per-bank register slices, write strobes decoded from group and slot
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = bus_we_i && aligned && (slot == 2'(b));

    irqfiq_bank #(.BANK_W(BANK_W)) i_bank (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .src_i      (src_i[b*BANK_W +: BANK_W]),
      .we_fpnd_i  (hit_bank && (grp == GRP_FPND)),
      .we_route_i (hit_bank && (grp == GRP_ROUTE)),
      .we_ena_i   (hit_bank && (grp == GRP_ENA)),
      .we_mask_i  (hit_bank && (grp == GRP_MASK)),
      .wdata_i    (bus_wdata_i),
      .pend_o     (pend[b]),
      .fpnd_o     (fpnd[b]),
      .route_o    (route[b]),
      .ena_o      (ena[b]),
      .mask_o     (mask[b]),
      .act_o      (act[b]),
      .fact_o     (fact[b])
    );

    assign any_act[b]  = |act[b];
    assign any_fact[b] = |fact[b];
  end

  assign irq_o = |any_act;
  assign fiq_o = |any_fact;

  irqfiq_scan #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .DATA_W    (DATA_W)
  ) i_scan (
    .act_i (act),
    .vec_o (vec)
  );

  // Control words
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else if (bus_we_i && aligned && (grp == GRP_CTRL)) begin
      case (ctrl_word_e'(slot))
        CW_BASE: base_q <= {bus_wdata_i[DATA_W-1:2], 2'b00};
        CW_PROT: prot_q <= bus_wdata_i;
        CW_NMI:  nmi_q  <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (aligned) begin
      if (grp == GRP_CTRL) begin
        case (ctrl_word_e'(slot))
          CW_VEC:  bus_rdata_o = vec;
          CW_BASE: bus_rdata_o = base_q;
          CW_PROT: bus_rdata_o = prot_q;
          CW_NMI:  bus_rdata_o = nmi_q;
          default: bus_rdata_o = '0;
        endcase
      end else if (slot_ok) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (slot == 2'(b)) begin
            case (grp)
              GRP_RAW:   bus_rdata_o = pend[b];
              GRP_FPND:  bus_rdata_o = fpnd[b];
              GRP_ROUTE: bus_rdata_o = route[b];
              GRP_ENA:   bus_rdata_o = ena[b];
              GRP_MASK:  bus_rdata_o = mask[b];
              default:   bus_rdata_o = '0;
            endcase
          end
        end
      end
    end
  end

  // R3: a fast request implies a normal request
  p_fiq_needs_irq_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    fiq_o |-> irq_o);

  // R4: vector is zero while nothing unmasked is pending
  p_vec_idle_zero_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !irq_o |-> (vec == '0));

  // R4: vector is word-aligned and inside the line range
  p_vec_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (vec[1:0] == 2'b00) && (vec < DATA_W'(NUM_SRC * 4)));

  // R7: stored base never has its low bits set
  p_base_low_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    base_q[1:0] == 2'b00);

  // R10: reset leaves requests low and control words cleared
  p_reset_clears_r10: assert property (@(posedge clk_i)
    rst_i |=> (!irq_o && !fiq_o && (base_q == '0) && (nmi_q == '0)));
endmodule

// File: tb/test_irqfiq_ctrl.sv
module test_irqfiq_ctrl;
  localparam int NSRC = 96;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src = '0;
  logic [9:0]      addr = '0;
  logic            we = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq, fiq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  irqfiq_ctrl i_irqfiq_ctrl (
    .clk_i       (clk),
    .rst_i       (rst),
    .src_i       (src),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .fiq_o       (fiq)
  );

  typedef struct packed {
    logic [95:0] src;
    logic [95:0] msk;
    logic [95:0] sel;
    logic        irq;
    logic        fiq;
    logic [31:0] vec;
  } row_t;

  // {bank2, bank1, bank0}
  localparam row_t TBL [7] = '{
    '{ {32'h0, 32'h0, 32'h0}, {32'h0, 32'h0, 32'h0}, {32'h0, 32'h0, 32'h0}, 1'b0, 1'b0, 32'd0 },
    '{ {32'h0, 32'h0, 32'h20}, {32'h0, 32'h0, 32'h0}, {32'h0, 32'h0, 32'h0}, 1'b1, 1'b0, 32'd20 },
    '{ {32'h1, 32'h8, 32'h0}, {32'h0, 32'h0, 32'h0}, {32'h1, 32'h0, 32'h0}, 1'b1, 1'b1, 32'd140 },
    '{ {32'h1, 32'h8, 32'h0}, {32'h0, 32'h8, 32'h0}, {32'h1, 32'h0, 32'h0}, 1'b1, 1'b1, 32'd256 },
    '{ {32'h80000000, 32'h0, 32'h0}, {32'h0, 32'h0, 32'h0}, {32'h0, 32'h0, 32'h0}, 1'b1, 1'b0, 32'd380 },
    '{ {32'h0, 32'h0, 32'h81}, {32'h0, 32'h0, 32'h1}, {32'h0, 32'h0, 32'h0}, 1'b1, 1'b0, 32'd28 },
    '{ {32'h0, 32'h0, 32'h4}, {32'h0, 32'h0, 32'h4}, {32'h0, 32'h0, 32'h4}, 1'b0, 1'b0, 32'd0 }
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_src(input logic [95:0] v);
    @(negedge clk);
    src = v;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10: everything reads zero after reset
    for (int a = 0; a < 'h60; a += 4) begin
      rd(10'(a), r);
      chk($sformatf("R10 reset word 0x%0h", a), r, 32'h0);
    end
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    chk("R10 fiq after reset", {31'b0, fiq}, 32'h0);

    // R2 R3 R4: table of line/mask/route patterns
    for (int k = 0; k < 7; k++) begin
      for (int b = 0; b < 3; b++) begin
        wr(10'('h50 + 4*b), TBL[k].msk[32*b +: 32]);
        wr(10'('h30 + 4*b), TBL[k].sel[32*b +: 32]);
      end
      set_src(TBL[k].src);
      chk($sformatf("R2 irq row %0d", k), {31'b0, irq}, {31'b0, TBL[k].irq});
      chk($sformatf("R3 fiq row %0d", k), {31'b0, fiq}, {31'b0, TBL[k].fiq});
      rd(10'h000, r);
      chk($sformatf("R4 vector row %0d", k), r, TBL[k].vec);
      for (int b = 0; b < 3; b++) begin
        rd(10'('h10 + 4*b), r);
        chk($sformatf("R1 raw bank %0d row %0d", b, k), r, TBL[k].src[32*b +: 32]);
      end
    end

    // R9: misaligned write must not touch route bank 0 (holds 0x4)
    wr(10'h031, 32'hFFFF_FFFF);
    rd(10'h030, r);
    chk("R9 misaligned write ignored", r, 32'h4);
    wr(10'h01C, 32'hFFFF_FFFF);
    rd(10'h01C, r);
    chk("R9 slot 3 reads zero", r, 32'h0);
    wr(10'h060, 32'h1234_5678);
    rd(10'h060, r);
    chk("R9 high offset reads zero", r, 32'h0);
    rd(10'h032, r);
    chk("R9 misaligned read zero", r, 32'h0);

    // Clean up masks, routes, sticky pending
    for (int b = 0; b < 3; b++) begin
      wr(10'('h50 + 4*b), 32'h0);
      wr(10'('h30 + 4*b), 32'h0);
      wr(10'('h20 + 4*b), 32'hFFFF_FFFF);
    end
    set_src('0);

    // R5: raw pending ignores writes
    set_src(96'h10);
    wr(10'h010, 32'h0);
    rd(10'h010, r);
    chk("R5 raw write dropped", r, 32'h10);
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, r);
    chk("R5 raw bank1 write dropped", r, 32'h0);

    // R4: vector write has no effect; bit 4 -> 16
    wr(10'h000, 32'h0000_0040);
    rd(10'h000, r);
    chk("R4 vector write ignored", r, 32'd16);

    // R8: enable stores data but has no effect on outputs
    wr(10'h048, 32'hFFFF_FFFF);
    rd(10'h048, r);
    chk("R8 enable readback", r, 32'hFFFF_FFFF);
    set_src('0);
    chk("R8 irq ignores enable", {31'b0, irq}, 32'h0);
    set_src(96'h2);
    chk("R8 irq with enable 0", {31'b0, irq}, 32'h1);
    rd(10'h000, r);
    chk("R8 vector with enable 0", r, 32'd4);
    set_src('0);

    // R6: sticky fast pending, write-one-to-clear, set wins
    wr(10'h034, 32'h200);
    set_src({32'h0, 32'h200, 32'h0});
    rd(10'h024, r);
    chk("R6 fast pending set", r, 32'h200);
    set_src('0);
    rd(10'h024, r);
    chk("R6 sticky after drop", r, 32'h200);
    wr(10'h024, 32'h1);
    rd(10'h024, r);
    chk("R6 clear other bit keeps", r, 32'h200);
    wr(10'h024, 32'h200);
    rd(10'h024, r);
    chk("R6 clear written bit", r, 32'h0);
    set_src({32'h0, 32'h200, 32'h0});
    wr(10'h024, 32'h200);
    rd(10'h024, r);
    chk("R6 set wins over clear", r, 32'h200);
    set_src('0);

    // R7: base low bits forced, protect/nmi store full word
    wr(10'h004, 32'hDEAD_BEEF);
    rd(10'h004, r);
    chk("R7 base low bits", r, 32'hDEAD_BEEC);
    wr(10'h008, 32'h1234_5677);
    rd(10'h008, r);
    chk("R7 protect", r, 32'h1234_5677);
    wr(10'h00C, 32'h8000_0003);
    rd(10'h00C, r);
    chk("R7 nmi", r, 32'h8000_0003);

    // R11: bank slot decode isolates banks
    wr(10'h058, 32'h0000_00A5);
    rd(10'h050, r);
    chk("R11 mask bank0 untouched", r, 32'h0);
    rd(10'h054, r);
    chk("R11 mask bank1 untouched", r, 32'h0);
    rd(10'h058, r);
    chk("R11 mask bank2 written", r, 32'hA5);

    // R10: reset mid-run clears everything
    wr(10'h030, 32'h1);
    set_src(96'h1);
    chk("R10 fiq before reset", {31'b0, fiq}, 32'h1);
    @(negedge clk);
    src = '0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 irq after mid reset", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 'h60; a += 4) begin
      rd(10'(a), r);
      chk($sformatf("R10 mid reset word 0x%0h", a), r, 32'h0);
    end

    finish_run();
  end
endmodule